// File: doc/BRIEF.md
# Dual-Phase Energy Pulse Generator

This block turns a stream of signed real-power samples into energy pulses for a mechanical register or a two-coil stepper. Every sample that arrives with its strobe is added into a signed energy accumulator. Whenever the stored energy reaches one quantum, either positive or negative, the block takes one quantum out, keeps whatever is left over, and requests one output pulse. The size of the quantum comes from a two-bit rate selector. Each step of the selector changes the quantum by a factor of four.

The pulses are active high and take turns on two outputs. The first pulse after reset or after a supply drop goes to `f1_out`, the next to `f2_out`, and so on. Pulse length is counted in ticks of a millisecond strobe. It is normally `PULSE_TICKS` ticks long. When requests come closer together than twice that length, the pulse shrinks to half the measured interval. A request that arrives while a pulse is high waits in a single slot. Samples whose magnitude is below a programmable creep floor are thrown away, so a meter with no load never advances.

Top module: `epg_energy_pulser`

## Requirements
- R1: While `rst_n` is low or `supply_ok` is low, at the next clock edge both outputs go low, the accumulated energy is cleared, and any waiting request is dropped.
- R2: The energy quantum is 2^(THR_LOG2 + 2·(3 − rate_sel)). So `rate_sel` = 3 gives the smallest quantum, 2^THR_LOG2, and each lower code multiplies it by four.
- R3: The accumulator is signed. When it holds at least +quantum, or at most −quantum, one quantum of the matching sign is removed, the remainder is kept, and one pulse is requested. At most one quantum is removed per clock.
- R4: A strobed sample whose magnitude is below `creep_min` is not added to the accumulator.
- R5: Issued pulses alternate between the two outputs, starting with `f1_out` after reset or after a supply drop.
- R6: When the two most recent requests are at least 2·PULSE_TICKS ticks apart, or when there is no earlier request since clearing, the pulse stays high for exactly PULSE_TICKS ticks. It falls only at an edge where `ms_tick` is high.
- R7: When the interval P, in ticks, between the two most recent requests is below 2·PULSE_TICKS, the pulse lasts max(⌊P/2⌋, 1) ticks.
- R8: A request made while a pulse is high is held in a one-entry slot and starts after the output has been low for one clock. Further requests that arrive while the slot is full are dropped.
- R9: From idle, a sample that makes the accumulator reach a quantum raises `f1_out` or `f2_out` at the third rising edge, counting the edge that captures the strobe as the first.
- R10: `f1_out` and `f2_out` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication. Low clears the block like reset |
| ms_tick | input | 1 | One-clock strobe every millisecond. It times pulse widths and request intervals |
| rate_sel | input | 2 | Quantum select. 3 selects the smallest quantum |
| sample_vld | input | 1 | Marks `sample_pwr` as a new sample |
| sample_pwr | input | PWR_W | Signed real-power sample, two's complement |
| creep_min | input | PWR_W | Unsigned magnitude floor. Smaller samples are ignored |
| f1_out | output | 1 | First phase pulse output, active high |
| f2_out | output | 1 | Second phase pulse output, active high |

## Verification
The bench checks where the residue goes after a crossing. A negative run that leaves −44 must give a pulse after exactly −212 more. A design that clears the accumulator, or that only counts positive energy, misses or adds pulses here. The bench pins down how the width shrinks: with a 26-cycle request spacing it expects three ticks, and with widely spaced requests it expects the full width. A wrong period counter gives the wrong tick count. A burst of crossings must give exactly two pulses, one running and one waiting. A deeper queue, or no queue at all, changes that count. The bench also checks that samples below the creep floor are dropped, that a supply drop clears the stored residue, and that the first rising edge lands on the third clock.

// File: rtl/epg_pkg.sv
// Package: shared types and helpers for the dual-phase energy pulse generator.
// Assumes: rate select codes are two bits wide, and code 3 is the fastest rate.
package epg_pkg;

    // Rate select codes, from the largest quantum to the smallest
    typedef enum logic [1:0] {
        RATE_SLOWEST = 2'd0,
        RATE_SLOW    = 2'd1,
        RATE_FAST    = 2'd2,
        RATE_FASTEST = 2'd3
    } rate_sel_e;

    // Each rate step scales the quantum by 2^RATE_STEP_LOG2
    localparam int RATE_STEP_LOG2 = 2;
    localparam int RATE_CODES     = 4;

    // Extra left shift of the quantum for a given rate code
    function automatic int rate_shift(input logic [1:0] sel);
        return RATE_STEP_LOG2 * ((RATE_CODES - 1) - int'(sel));
    endfunction

endpackage

// File: rtl/epg_accum.sv
// Module: signed energy accumulator with a creep floor.
// Adds each strobed sample whose magnitude reaches creep_min, removes one
// quantum per clock whenever |energy| >= quantum, keeps the remainder, and
// registers a one-clock crossing request.
// Assumes: ACC_W leaves headroom above the largest quantum plus one sample.
module epg_accum
    import epg_pkg::*;
#(
    parameter int PWR_W    = 24,
    parameter int THR_LOG2 = 12,
    parameter int ACC_W    = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [1:0]              rate_sel,
    input  logic                    sample_vld,
    input  logic [PWR_W-1:0]        sample_pwr,
    input  logic [PWR_W-1:0]        creep_min,
    output logic signed [ACC_W-1:0] energy_q,
    output logic                    cross_q
);

    logic signed [PWR_W:0]   s_ext;
    logic        [PWR_W:0]   s_mag;
    logic                    s_keep;
    logic signed [ACC_W-1:0] s_add;
    logic signed [ACC_W-1:0] quantum;
    logic                    over_pos;
    logic                    over_neg;
    logic signed [ACC_W-1:0] q_adj;
    logic signed [ACC_W-1:0] energy_d;

    // Sample magnitude and the creep decision
    always_comb begin
        s_ext  = {sample_pwr[PWR_W-1], sample_pwr};
        s_mag  = s_ext[PWR_W] ? $unsigned(-s_ext) : $unsigned(s_ext);
        s_keep = sample_vld && (s_mag >= {1'b0, creep_min});
        s_add  = s_keep ? {{(ACC_W-PWR_W){sample_pwr[PWR_W-1]}}, sample_pwr}
                        : '0;
    end

    // Quantum for the selected rate
    always_comb begin
        quantum = {{(ACC_W-1){1'b0}}, 1'b1} << (THR_LOG2 + rate_shift(rate_sel));
    end

    // Threshold crossing in either direction and the matching correction
    always_comb begin
        over_pos = (energy_q >= quantum);
        over_neg = (energy_q <= -quantum);
        if (over_pos)
            q_adj = -quantum;
        else if (over_neg)
            q_adj = quantum;
        else
            q_adj = '0;
        energy_d = energy_q + s_add + q_adj;
    end

    // Energy register and the registered crossing request
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            energy_q <= '0;
            cross_q  <= 1'b0;
        end else begin
            energy_q <= energy_d;
            cross_q  <= over_pos || over_neg;
        end
    end

endmodule

// File: rtl/epg_period.sv
// Module: request interval meter and pulse width selector.
// Counts ms ticks since the last request, saturating at 2*PULSE_TICKS, and
// gives the width for a request arriving now: full width for a long or
// unknown interval, otherwise half the interval (never below one tick).
// Assumes: req is a one-clock strobe.
module epg_period #(
    parameter int PULSE_TICKS = 275,
    parameter int WID_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ms_tick,
    input  logic             req,
    output logic [WID_W-1:0] req_width
);

    localparam int               CAP   = 2 * PULSE_TICKS;
    localparam logic [WID_W-1:0] CAP_V = WID_W'(CAP);
    localparam logic [WID_W-1:0] FULL  = WID_W'(PULSE_TICKS);
    localparam logic [WID_W-1:0] ONE   = WID_W'(1);

    logic [WID_W-1:0] per_q;
    logic [WID_W-1:0] half;

    // Width for a request seen in this cycle
    always_comb begin
        half = per_q >> 1;
        if (per_q < CAP_V)
            req_width = (half == '0) ? ONE : half;
        else
            req_width = FULL;
    end

    // Tick counter since the last request, saturating at the cap
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            per_q <= CAP_V;
        else if (req)
            per_q <= '0;
        else if (ms_tick && (per_q < CAP_V))
            per_q <= per_q + ONE;
    end

endmodule

// File: rtl/epg_pulse.sv
// Module: alternating two-phase pulse driver with a one-entry request slot.
// Starts a pulse of the requested width on whichever output is next, holds
// one request while busy, and drops any request beyond that.
// Assumes: the width arriving with each request is at least one tick.
module epg_pulse #(
    parameter int WID_W = 10,
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ms_tick,
    input  logic             req,
    input  logic [WID_W-1:0] req_width,
    output logic [N_OUT-1:0] pulse_out
);

    localparam logic [WID_W-1:0] ONE = WID_W'(1);

    logic             on_q;
    logic             act_q;
    logic             nxt_q;
    logic             pend_q;
    logic [WID_W-1:0] hi_q;
    logic [WID_W-1:0] cw_q;
    logic [WID_W-1:0] pw_q;

    // Pulse sequencing: width count, slot, and phase steering
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            on_q   <= 1'b0;
            act_q  <= 1'b0;
            nxt_q  <= 1'b0;
            pend_q <= 1'b0;
            hi_q   <= '0;
            cw_q   <= '0;
            pw_q   <= '0;
        end else if (on_q) begin
            if (ms_tick) begin
                if ((hi_q + ONE) >= cw_q)
                    on_q <= 1'b0;
                else
                    hi_q <= hi_q + ONE;
            end
            if (req && !pend_q) begin
                pend_q <= 1'b1;
                pw_q   <= req_width;
            end
        end else if (pend_q) begin
            on_q   <= 1'b1;
            hi_q   <= '0;
            cw_q   <= pw_q;
            act_q  <= nxt_q;
            nxt_q  <= ~nxt_q;
            pend_q <= req;
            pw_q   <= req_width;
        end else if (req) begin
            on_q  <= 1'b1;
            hi_q  <= '0;
            cw_q  <= req_width;
            act_q <= nxt_q;
            nxt_q <= ~nxt_q;
        end
    end

    // One output per phase; only the active phase follows the pulse
    for (genvar g = 0; g < N_OUT; g++) begin : g_phase
        assign pulse_out[g] = on_q && (act_q == 1'(g));
    end

endmodule

// File: rtl/epg_energy_pulser.sv
// Module: top of the dual-phase energy pulse generator.
// Chains the accumulator, the interval meter and the pulse driver. A low
// supply_ok acts as a synchronous clear of every stage.
// Assumes: ms_tick is a one-clock strobe, and samples do not arrive every
// clock faster than one quantum per clock can drain them.
module epg_energy_pulser #(
    parameter int PWR_W       = 24,
    parameter int THR_LOG2    = 12,
    parameter int PULSE_TICKS = 275
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             ms_tick,
    input  logic [1:0]       rate_sel,
    input  logic             sample_vld,
    input  logic [PWR_W-1:0] sample_pwr,
    input  logic [PWR_W-1:0] creep_min,
    output logic             f1_out,
    output logic             f2_out
);

    localparam int TOP_Q_LOG2 = THR_LOG2 + 6;
    localparam int ACC_W      = ((TOP_Q_LOG2 > PWR_W) ? TOP_Q_LOG2 : PWR_W) + 2;
    localparam int WID_W      = $clog2(2 * PULSE_TICKS + 1);

    logic                    clr;
    logic signed [ACC_W-1:0] energy_q;
    logic                    cross_q;
    logic [WID_W-1:0]        req_width;
    logic [1:0]              pulse_out;

    // Supply loss clears the whole datapath
    assign clr = !supply_ok;

    epg_accum #(
        .PWR_W   (PWR_W),
        .THR_LOG2(THR_LOG2),
        .ACC_W   (ACC_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .rate_sel  (rate_sel),
        .sample_vld(sample_vld),
        .sample_pwr(sample_pwr),
        .creep_min (creep_min),
        .energy_q  (energy_q),
        .cross_q   (cross_q)
    );

    epg_period #(
        .PULSE_TICKS(PULSE_TICKS),
        .WID_W      (WID_W)
    ) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .ms_tick  (ms_tick),
        .req      (cross_q),
        .req_width(req_width)
    );

    epg_pulse #(
        .WID_W(WID_W),
        .N_OUT(2)
    ) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .ms_tick  (ms_tick),
        .req      (cross_q),
        .req_width(req_width),
        .pulse_out(pulse_out)
    );

    assign f1_out = pulse_out[0];
    assign f2_out = pulse_out[1];

endmodule

// File: rtl/epg_energy_pulser_chk.sv
// Module: assertion checker for epg_energy_pulser, attached with bind.
// Watches the ports and the stored energy.
// Assumes: the same parameters as the instance it is bound to.
module epg_energy_pulser_chk #(
    parameter int PWR_W       = 24,
    parameter int THR_LOG2    = 12,
    parameter int PULSE_TICKS = 275,
    parameter int ACC_W       = 26
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    supply_ok,
    input logic                    ms_tick,
    input logic                    sample_vld,
    input logic [PWR_W-1:0]        sample_pwr,
    input logic [PWR_W-1:0]        creep_min,
    input logic                    f1_out,
    input logic                    f2_out,
    input logic signed [ACC_W-1:0] energy_q
);

    localparam logic signed [ACC_W-1:0] MIN_Q = {{(ACC_W-1){1'b0}}, 1'b1} << THR_LOG2;

    logic signed [PWR_W:0] s_ext;
    logic        [PWR_W:0] s_mag;
    logic                  small_smp;
    logic                  small_eng;
    logic                  f1_d;
    logic                  f2_d;
    logic                  last_f1;
    logic [31:0]           hi_ticks;

    // Sample magnitude and stored energy, both below the smallest quantum
    always_comb begin
        s_ext     = {sample_pwr[PWR_W-1], sample_pwr};
        s_mag     = s_ext[PWR_W] ? $unsigned(-s_ext) : $unsigned(s_ext);
        small_smp = sample_vld && (s_mag < {1'b0, creep_min});
        small_eng = (energy_q < MIN_Q) && (energy_q > -MIN_Q);
    end

    // Previous output levels, used to find rising edges
    always_ff @(posedge clk) begin
        f1_d <= f1_out;
        f2_d <= f2_out;
    end

    // Which phase rose last, and ticks seen during the current pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            last_f1  <= 1'b0;
            hi_ticks <= '0;
        end else begin
            if (f1_out && !f1_d)
                last_f1 <= 1'b1;
            else if (f2_out && !f2_d)
                last_f1 <= 1'b0;
            if (f1_out || f2_out) begin
                if (ms_tick)
                    hi_ticks <= hi_ticks + 32'd1;
            end else begin
                hi_ticks <= '0;
            end
        end
    end

    AST_SUPPLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!f1_out && !f2_out)); // R1

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(f1_out && f2_out)); // R10

    AST_F1_TURN: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
        (f1_out && !f1_d) |-> !last_f1); // R5

    AST_F2_TURN: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
        (f2_out && !f2_d) |-> last_f1); // R5

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (f1_out && !ms_tick && supply_ok) |=> f1_out); // R6

    AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        hi_ticks <= 32'(PULSE_TICKS)); // R7

    AST_CREEP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && small_smp && small_eng) |=> $stable(energy_q)); // R4

endmodule

bind epg_energy_pulser epg_energy_pulser_chk #(
    .PWR_W      (PWR_W),
    .THR_LOG2   (THR_LOG2),
    .PULSE_TICKS(PULSE_TICKS),
    .ACC_W      (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .ms_tick   (ms_tick),
    .sample_vld(sample_vld),
    .sample_pwr(sample_pwr),
    .creep_min (creep_min),
    .f1_out    (f1_out),
    .f2_out    (f2_out),
    .energy_q  (energy_q)
);

// File: tb/epg_energy_pulser_test.sv
`timescale 1ns/1ps
module epg_energy_pulser_test;

    localparam int PW  = 12;
    localparam int QL  = 8;
    localparam int W   = 6;
    localparam int CAP = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          supply_ok;
    logic          ms_tick;
    logic [1:0]    rate_sel;
    logic          sample_vld;
    logic [PW-1:0] sample_pwr;
    logic [PW-1:0] creep_min;
    logic          f1_out;
    logic          f2_out;

    epg_energy_pulser #(.PWR_W(PW), .THR_LOG2(QL), .PULSE_TICKS(W)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ms_tick(ms_tick),
        .rate_sel(rate_sel), .sample_vld(sample_vld), .sample_pwr(sample_pwr),
        .creep_min(creep_min), .f1_out(f1_out), .f2_out(f2_out)
    );

    always #2.5 clk = ~clk;

    int    n_checks = 0;
    int    n_err    = 0;
    bit    done     = 1'b0;
    string phase    = "R1";
    int    rises    = 0;
    int    cur_w    = 0;
    int    last_w   = 0;
    bit    f1_p     = 1'b0;
    bit    f2_p     = 1'b0;

    // Reference model state
    int m_acc = 0, m_per = CAP, m_hi = 0, m_cw = 0, m_pw = 0;
    bit m_req = 0, m_on = 0, m_act = 0, m_nxt = 0, m_pend = 0;
    int q, sv, add, wreq, nacc;
    bit crs;

    task automatic chk(input string tag, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference, evaluated from the pre-edge state
    always @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            m_acc = 0; m_req = 0; m_per = CAP; m_on = 0; m_hi = 0; m_cw = 0;
            m_act = 0; m_nxt = 0; m_pend = 0; m_pw = 0;
        end else begin
            q    = 1 << (QL + 2 * (3 - int'(rate_sel)));
            sv   = int'($signed(sample_pwr));
            crs  = (m_acc >= q) || (m_acc <= -q);
            add  = (sample_vld && ((sv < 0 ? -sv : sv) >= int'(creep_min))) ? sv : 0;
            wreq = (m_per < CAP) ? (((m_per / 2) == 0) ? 1 : m_per / 2) : W;
            nacc = m_acc + add + (crs ? ((m_acc > 0) ? -q : q) : 0);
            if (m_on) begin
                if (ms_tick) begin
                    if (m_hi + 1 >= m_cw) m_on = 0; else m_hi++;
                end
                if (m_req && !m_pend) begin m_pend = 1; m_pw = wreq; end
            end else if (m_pend) begin
                m_on = 1; m_hi = 0; m_cw = m_pw; m_act = m_nxt; m_nxt = !m_nxt;
                m_pend = m_req; m_pw = wreq;
            end else if (m_req) begin
                m_on = 1; m_hi = 0; m_cw = wreq; m_act = m_nxt; m_nxt = !m_nxt;
            end
            if (m_req) m_per = 0;
            else if (ms_tick && m_per < CAP) m_per++;
            m_acc = nacc;
            m_req = crs;
        end
    end

    // Ticks counted across each DUT pulse
    always @(posedge clk) begin
        if (f1_out || f2_out) begin
            if (ms_tick) cur_w++;
        end else if (cur_w != 0) begin
            last_w = cur_w;
            cur_w  = 0;
        end
    end

    // Per-cycle comparison against the model, plus rising-edge count
    always @(negedge clk) begin
        if (rst_n !== 1'bx) begin
            chk(phase, int'(f1_out), int'(m_on && !m_act), "f1_out vs model");
            chk(phase, int'(f2_out), int'(m_on && m_act), "f2_out vs model");
            chk("R10", int'(f1_out && f2_out), 0, "both phases high");
        end
        if (f1_out && !f1_p) rises++;
        if (f2_out && !f2_p) rises++;
        f1_p = f1_out;
        f2_p = f2_out;
    end

    // Millisecond strobe: one clock in four
    initial begin
        int tc;
        tc = 0;
        ms_tick = 1'b0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % 4;
            ms_tick = (tc == 0);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int v);
        @(negedge clk);
        sample_vld = 1'b1;
        sample_pwr = PW'(v);
        @(negedge clk);
        sample_vld = 1'b0;
        sample_pwr = '0;
    endtask

    task automatic clear_supply();
        @(negedge clk);
        supply_ok = 1'b0;
        idle(2);
        supply_ok = 1'b1;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    endtask

    initial begin
        rst_n = 1'b0; supply_ok = 1'b1; rate_sel = 2'd3;
        sample_vld = 1'b0; sample_pwr = '0; creep_min = '0;
        idle(5);
        chk("R1", int'(f1_out || f2_out), 0, "outputs during reset");
        rst_n = 1'b1;

        // R9 latency and R5 first phase: 300 crosses 256, remainder 44
        phase = "R9";
        send(300);
        chk("R9", int'(f1_out), 0, "f1 one edge after strobe");
        idle(1);
        chk("R9", int'(f1_out), 0, "f1 two edges after strobe");
        idle(1);
        chk("R9", int'(f1_out), 1, "f1 three edges after strobe");
        chk("R5", int'(f2_out), 0, "first pulse not on f2");
        idle(40);
        phase = "R5";
        send(212);   // 44 + 212 = 256
        idle(2);
        chk("R5", int'(f2_out), 1, "second pulse on f2");
        idle(60);

        // R6: widely spaced requests get the full width
        phase = "R6";
        send(256); idle(200);
        send(256); idle(60);
        chk("R6", last_w, W, "full width ticks");

        // R7: 26-cycle spacing gives a 6 or 7 tick interval, so 3 ticks
        phase = "R7";
        rises = 0;
        for (int i = 0; i < 5; i++) begin
            send(256);
            idle(24);
        end
        idle(30);
        chk("R7", last_w, 3, "half-interval width ticks");
        chk("R7", rises, 5, "pulses for five quanta");

        // R8: burst of crossings gives one running pulse and one waiting
        phase = "R8";
        clear_supply();
        idle(100);
        rises = 0;
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            sample_vld = 1'b1; sample_pwr = PW'(200);
            @(negedge clk);
        end
        sample_vld = 1'b0; sample_pwr = '0;
        idle(100);
        chk("R8", rises, 2, "pulses from a burst");

        // R4: samples below the creep floor never accumulate
        phase = "R4";
        clear_supply();
        creep_min = PW'(50);
        rises = 0;
        for (int i = 0; i < 10; i++) begin send(40); send(-45); end
        idle(20);
        chk("R4", rises, 0, "pulses from sub-floor samples");
        send(300);
        idle(10);
        chk("R4", rises, 1, "sample at or above floor counts");
        creep_min = '0;
        idle(40);

        // R2: rate code 2 sets a quantum of 1024
        phase = "R2";
        clear_supply();
        rate_sel = 2'd2;
        rises = 0;
        for (int i = 0; i < 5; i++) send(200);
        idle(10);
        chk("R2", rises, 0, "1000 below quantum 1024");
        send(200);
        idle(5);
        chk("R2", rises, 1, "1200 crosses quantum 1024");
        idle(40);
        rate_sel = 2'd3;

        // R3: negative energy, remainder kept (-400 -> -144 -> -44 -> -256)
        phase = "R3";
        clear_supply();
        rises = 0;
        send(-200); send(-200); idle(40);
        chk("R3", rises, 1, "negative quantum pulse");
        send(100); idle(40);
        chk("R3", rises, 1, "no pulse at -44");
        send(-212); idle(40);
        chk("R3", rises, 2, "remainder completes quantum");

        // R1: a supply drop clears residue and stops a running pulse
        phase = "R1";
        clear_supply();
        rises = 0;
        send(200);
        clear_supply();
        send(100); idle(20);
        chk("R1", rises, 0, "residue cleared by supply drop");
        send(300); idle(6);
        chk("R1", int'(f1_out || f2_out), 1, "pulse running before drop");
        supply_ok = 1'b0;
        idle(1);
        chk("R1", int'(f1_out || f2_out), 0, "outputs after supply drop");
        idle(3);
        supply_ok = 1'b1;
        idle(20);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: run did not finish (all requirements)");
            summary();
            $finish;
        end
    end

endmodule